// File: doc/BRIEF.md
# Rectangle Blit Engine with Raster Mix

The block is a small 2D graphics engine that operates on a rectangle of 8-bit pixels held in a byte-addressed linear frame buffer. Software first programs the source and destination start addresses, a row pitch for each map, the rectangle size, a foreground colour and a control word. The control word holds the mix code, the traversal direction per axis, the draw mode, the foreground operand select and the operation code. A write to the launch register then starts the operation.

The engine walks the rectangle one pixel at a time. For each pixel it fetches the foreground operand (S) and the destination pixel (D) over a single memory port. It combines them with one of sixteen two-operand logic mixes, optionally inverts the result, and writes it back to the destination. While the operation runs, bit 7 of the status byte reads 1. The memory port carries one request at a time under a valid/ready handshake. Read data returns later on a separate response strobe.

Top module: `blit_engine`

## Requirements
- R1: After reset, the status byte is 0x00 and no memory request is raised; whenever the engine is idle, no memory request is raised.
- R2: Configuration writes use indices 0 source start, 1 destination start, 2 source pitch, 3 destination pitch, 4 width minus one, 5 height minus one, 6 foreground colour, 7 control, 8 launch. Control fields are mix [3:0], X-reverse [4], Y-reverse [5], draw mode [7:6], foreground-from-source [8] and operation [15:12]. A launch write with operation 0x8 or 0x9 sets status bit 7 from the next cycle. Any other operation value leaves the engine idle with no memory traffic.
- R3: A drawn pixel produces, in this order, a source read (only when foreground-from-source is 1), a destination read, and then a write to that same destination address. At most one request is outstanding, and a request not yet accepted holds its address, direction and data.
- R4: Width and height registers hold the size minus one (12 bits). Pixel (x, y) lies at start + y*pitch + x modulo 2^22, with pitches of 12 bits. Rows are processed one after another, and each row is walked completely before the next.
- R5: With X-reverse set, the column offset is -x; with Y-reverse set, the row offset is -y*pitch.
- R6: The mix code selects the result: 0 zero, 1 S&D, 2 S&~D, 3 S, 4 ~S&D, 5 D, 6 S^D, 7 S|D, 8 ~S&~D, 9 S^~D, A ~D, B S|~D, C ~S, D ~S|D, E ~S|~D, F all ones.
- R7: Operation 0x9 writes the bitwise inverse of the mix result, and operation 0x8 writes the mix result unchanged.
- R8: With foreground-from-source at 0, S is the foreground colour register and no source reads are issued.
- R9: Draw mode 1 skips the first pixel of every row and draw mode 2 skips the last pixel of every row. Modes 0 and 3 draw every pixel. A skipped pixel causes no memory traffic.
- R10: Configuration writes made while status bit 7 is set are ignored, both by the running operation and by later ones.
- R11: Status bit 7 stays set until the last pixel is finished and reads 0 in the cycle after the last write is accepted, or in the cycle after the last pixel is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| status | output | 8 | Status byte, bit 7 busy, other bits 0 |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted when high with mem_valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 22 | Byte address of the request |
| mem_wdata | output | 8 | Write data |
| mem_rvalid | input | 1 | Read response strobe |
| mem_rdata | input | 8 | Read response data |

## Verification
A launch is accepted at the clock edge that samples the write, so the bench reads status bit 7 at the next falling edge. A rejected launch must show 0 at that same falling edge. The memory model records the cycle in which it accepts each write. The bench then requires busy to be low at the falling edge exactly one cycle after the final write, whenever the last pixel is drawn and not skipped. The frame-buffer contents and the access counts are compared only once busy has dropped. Write data is committed at acceptance, so no comparison depends on when the model stores the data.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PIX,
    ST_SREQ,
    ST_SWAIT,
    ST_DREQ,
    ST_DWAIT,
    ST_WREQ
  } blit_state_e;

  localparam logic [3:0] IDX_SRC_START = 4'd0;
  localparam logic [3:0] IDX_DST_START = 4'd1;
  localparam logic [3:0] IDX_SRC_PITCH = 4'd2;
  localparam logic [3:0] IDX_DST_PITCH = 4'd3;
  localparam logic [3:0] IDX_WIDTH     = 4'd4;
  localparam logic [3:0] IDX_HEIGHT    = 4'd5;
  localparam logic [3:0] IDX_FG_COLOUR = 4'd6;
  localparam logic [3:0] IDX_CONTROL   = 4'd7;
  localparam logic [3:0] IDX_LAUNCH    = 4'd8;

  localparam logic [3:0] OPC_COPY     = 4'h8;
  localparam logic [3:0] OPC_COPY_INV = 4'h9;

  localparam logic [1:0] DM_SKIP_FIRST = 2'd1;
  localparam logic [1:0] DM_SKIP_LAST  = 2'd2;

endpackage

// File: rtl/blit_mix.sv
module blit_mix #(
  parameter int PIX_W = 8
) (
  input  logic [3:0]       mix_code,
  input  logic             invert,
  input  logic [PIX_W-1:0] s_op,
  input  logic [PIX_W-1:0] d_op,
  output logic [PIX_W-1:0] result
);

  function automatic logic [PIX_W-1:0] apply_mix(input logic [3:0] code,
                                                 input logic [PIX_W-1:0] s,
                                                 input logic [PIX_W-1:0] d);
    logic [PIX_W-1:0] r;
    case (code)
      4'h0: r = '0;
      4'h1: r = s & d;
      4'h2: r = s & ~d;
      4'h3: r = s;
      4'h4: r = ~s & d;
      4'h5: r = d;
      4'h6: r = s ^ d;
      4'h7: r = s | d;
      4'h8: r = ~s & ~d;
      4'h9: r = s ^ ~d;
      4'hA: r = ~d;
      4'hB: r = s | ~d;
      4'hC: r = ~s;
      4'hD: r = ~s | d;
      4'hE: r = ~s | ~d;
      default: r = '1;
    endcase
    return r;
  endfunction

  logic [PIX_W-1:0] raw;
  assign raw    = apply_mix(mix_code, s_op, d_op);
  assign result = invert ? ~raw : raw;

endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
  parameter int ADDR_W = 22,
  parameter int DIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [DIM_W-1:0]  width_m1,
  input  logic [DIM_W-1:0]  height_m1,
  input  logic              x_neg,
  input  logic              y_neg,
  input  logic [ADDR_W-1:0] src_start,
  input  logic [ADDR_W-1:0] dst_start,
  input  logic [DIM_W-1:0]  src_pitch,
  input  logic [DIM_W-1:0]  dst_pitch,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              row_first,
  output logic              row_last,
  output logic              last_pix
);

  function automatic logic [ADDR_W-1:0] pix_addr(input logic [ADDR_W-1:0] base,
                                                 input logic [DIM_W-1:0]  pitch,
                                                 input logic [DIM_W-1:0]  xc,
                                                 input logic [DIM_W-1:0]  yc,
                                                 input logic              xn,
                                                 input logic              yn);
    logic [ADDR_W-1:0] row_off;
    logic [ADDR_W-1:0] col_off;
    row_off = ADDR_W'(yc) * ADDR_W'(pitch);
    col_off = ADDR_W'(xc);
    return base + (yn ? -row_off : row_off) + (xn ? -col_off : col_off);
  endfunction

  logic [DIM_W-1:0] x_q;
  logic [DIM_W-1:0] y_q;

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      x_q <= '0;
      y_q <= '0;
    end else if (step) begin
      if (x_q == width_m1) begin
        x_q <= '0;
        y_q <= y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  assign row_first = (x_q == '0);
  assign row_last  = (x_q == width_m1);
  assign last_pix  = row_last && (y_q == height_m1);
  assign src_addr  = pix_addr(src_start, src_pitch, x_q, y_q, x_neg, y_neg);
  assign dst_addr  = pix_addr(dst_start, dst_pitch, x_q, y_q, x_neg, y_neg);

endmodule

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DIM_W  = 12,
  parameter int PIX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [3:0]        idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  output logic [ADDR_W-1:0] src_start,
  output logic [ADDR_W-1:0] dst_start,
  output logic [DIM_W-1:0]  src_pitch,
  output logic [DIM_W-1:0]  dst_pitch,
  output logic [DIM_W-1:0]  width_m1,
  output logic [DIM_W-1:0]  height_m1,
  output logic [PIX_W-1:0]  fg_colour,
  output logic [3:0]        mix_code,
  output logic              x_neg,
  output logic              y_neg,
  output logic [1:0]        draw_mode,
  output logic              fg_from_src,
  output logic [3:0]        opcode,
  output logic              go_accept
);

  logic wr_ok;
  logic op_known;
  logic unused_high;

  assign wr_ok       = we && !busy;
  assign op_known    = (opcode == OPC_COPY) || (opcode == OPC_COPY_INV);
  assign go_accept   = wr_ok && (idx == IDX_LAUNCH) && op_known;
  assign unused_high = ^wdata[DATA_W-1:ADDR_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_start   <= '0;
      dst_start   <= '0;
      src_pitch   <= '0;
      dst_pitch   <= '0;
      width_m1    <= '0;
      height_m1   <= '0;
      fg_colour   <= '0;
      mix_code    <= '0;
      x_neg       <= 1'b0;
      y_neg       <= 1'b0;
      draw_mode   <= '0;
      fg_from_src <= 1'b0;
      opcode      <= '0;
    end else if (wr_ok) begin
      case (idx)
        IDX_SRC_START: src_start <= wdata[ADDR_W-1:0];
        IDX_DST_START: dst_start <= wdata[ADDR_W-1:0];
        IDX_SRC_PITCH: src_pitch <= wdata[DIM_W-1:0];
        IDX_DST_PITCH: dst_pitch <= wdata[DIM_W-1:0];
        IDX_WIDTH:     width_m1  <= wdata[DIM_W-1:0];
        IDX_HEIGHT:    height_m1 <= wdata[DIM_W-1:0];
        IDX_FG_COLOUR: fg_colour <= wdata[PIX_W-1:0];
        IDX_CONTROL: begin
          mix_code    <= wdata[3:0];
          x_neg       <= wdata[4];
          y_neg       <= wdata[5];
          draw_mode   <= wdata[7:6];
          fg_from_src <= wdata[8];
          opcode      <= wdata[15:12];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DIM_W  = 12,
  parameter int PIX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_idx,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [7:0]        status,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic              mem_rvalid,
  input  logic [PIX_W-1:0]  mem_rdata
);

  logic [ADDR_W-1:0] src_start, dst_start, src_addr, dst_addr;
  logic [DIM_W-1:0]  src_pitch, dst_pitch, width_m1, height_m1;
  logic [PIX_W-1:0]  fg_colour, s_q, d_q, s_op, mix_out;
  logic [3:0]        mix_code, opcode;
  logic [1:0]        draw_mode;
  logic              x_neg, y_neg, fg_from_src;
  logic              go_accept, busy, skip_now, pix_done, op_done;
  logic              row_first, row_last, last_pix;
  blit_state_e       state_q, state_d;

  blit_regs #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .PIX_W(PIX_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata), .busy(busy),
    .src_start(src_start), .dst_start(dst_start), .src_pitch(src_pitch),
    .dst_pitch(dst_pitch), .width_m1(width_m1), .height_m1(height_m1),
    .fg_colour(fg_colour), .mix_code(mix_code), .x_neg(x_neg), .y_neg(y_neg),
    .draw_mode(draw_mode), .fg_from_src(fg_from_src), .opcode(opcode),
    .go_accept(go_accept)
  );

  blit_walker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) walk_i (
    .clk(clk), .rst_n(rst_n), .load(go_accept), .step(pix_done),
    .width_m1(width_m1), .height_m1(height_m1), .x_neg(x_neg), .y_neg(y_neg),
    .src_start(src_start), .dst_start(dst_start), .src_pitch(src_pitch),
    .dst_pitch(dst_pitch), .src_addr(src_addr), .dst_addr(dst_addr),
    .row_first(row_first), .row_last(row_last), .last_pix(last_pix)
  );

  assign s_op = fg_from_src ? s_q : fg_colour;

  blit_mix #(.PIX_W(PIX_W)) mix_i (
    .mix_code(mix_code), .invert(opcode == OPC_COPY_INV),
    .s_op(s_op), .d_op(d_q), .result(mix_out)
  );

  // named internal events used by the bound checker
  assign busy     = (state_q != ST_IDLE);
  assign skip_now = ((draw_mode == DM_SKIP_FIRST) && row_first) ||
                    ((draw_mode == DM_SKIP_LAST) && row_last);
  assign pix_done = ((state_q == ST_PIX) && skip_now) ||
                    ((state_q == ST_WREQ) && mem_ready);
  assign op_done  = pix_done && last_pix;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (go_accept) state_d = ST_PIX;
      ST_PIX: begin
        if (skip_now)         state_d = last_pix ? ST_IDLE : ST_PIX;
        else if (fg_from_src) state_d = ST_SREQ;
        else                  state_d = ST_DREQ;
      end
      ST_SREQ:  if (mem_ready)  state_d = ST_SWAIT;
      ST_SWAIT: if (mem_rvalid) state_d = ST_DREQ;
      ST_DREQ:  if (mem_ready)  state_d = ST_DWAIT;
      ST_DWAIT: if (mem_rvalid) state_d = ST_WREQ;
      ST_WREQ:  if (mem_ready)  state_d = last_pix ? ST_IDLE : ST_PIX;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      s_q     <= '0;
      d_q     <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_SWAIT && mem_rvalid) s_q <= mem_rdata;
      if (state_q == ST_DWAIT && mem_rvalid) d_q <= mem_rdata;
    end
  end

  assign mem_valid = (state_q == ST_SREQ) || (state_q == ST_DREQ) || (state_q == ST_WREQ);
  assign mem_we    = (state_q == ST_WREQ);
  assign mem_addr  = (state_q == ST_SREQ) ? src_addr : dst_addr;
  assign mem_wdata = mix_out;
  assign status    = {busy, 7'b0};

endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk #(
  parameter int ADDR_W = 22,
  parameter int DIM_W  = 12,
  parameter int PIX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              go_accept,
  input logic              op_done,
  input logic              cfg_we,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [PIX_W-1:0]  mem_wdata,
  input logic              mem_rvalid,
  input logic [ADDR_W-1:0] src_start,
  input logic [ADDR_W-1:0] dst_start,
  input logic [DIM_W-1:0]  width_m1,
  input logic [3:0]        mix_code
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);

  assert_launch_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go_accept |=> busy);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

  assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> !mem_valid);

  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we) |=> ($stable(src_start) && $stable(dst_start) &&
                          $stable(width_m1) && $stable(mix_code)));

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !busy);

  assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_done) |=> busy);

endmodule

bind blit_engine blit_engine_chk #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .PIX_W(PIX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .go_accept(go_accept), .op_done(op_done),
  .cfg_we(cfg_we), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
  .src_start(src_start), .dst_start(dst_start), .width_m1(width_m1), .mix_code(mix_code)
);

// File: tb/blit_engine_tb_top.sv
module blit_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 22;
  localparam int PW = 8;
  localparam int MEMSZ = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_idx = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [7:0]    status;
  logic          mem_valid, mem_we;
  logic [AW-1:0] mem_addr;
  logic [PW-1:0] mem_wdata;
  logic          mem_ready = 1'b0;
  logic          mem_rvalid = 1'b0;
  logic [PW-1:0] mem_rdata = '0;

  blit_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .status(status), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  logic [7:0] mem [0:MEMSZ-1];
  logic [7:0] ref_mem [0:MEMSZ-1];

  // memory model state
  logic          acc = 1'b0;
  logic          acc_we = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [15:0]   lfsr = 16'hACE1;
  int wr_cnt, rd_cnt, order_err, oor, last_wr_cyc;
  logic          prev_was_rd = 1'b0;
  logic [AW-1:0] prev_addr = '0;

  // operation parameters
  int p_src, p_dst, p_sp, p_dp, p_w, p_h, p_fg, p_mix, p_xn, p_yn, p_dm, p_fs, p_op;
  int exp_wr, exp_rd;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // memory: decide acceptance at the falling edge; the handshake completes at the next rising edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      mem_rvalid = 1'b0;
      acc = 1'b0;
    end else begin
      mem_rvalid = 1'b0;
      if (acc && !acc_we) begin
        mem_rvalid = 1'b1;
        mem_rdata = mem[acc_addr[9:0]];
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ready = lfsr[0] | lfsr[3];
      acc = mem_valid && mem_ready;
      if (acc) begin
        acc_we = mem_we;
        acc_addr = mem_addr;
        if (mem_addr[AW-1:10] != '0) oor++;
        if (mem_we) begin
          mem[mem_addr[9:0]] = mem_wdata;
          wr_cnt++;
          last_wr_cyc = cyc;
          if (!(prev_was_rd && prev_addr == mem_addr)) order_err++;
        end else begin
          rd_cnt++;
        end
        prev_was_rd = !mem_we;
        prev_addr = mem_addr;
      end
    end
  end

  function automatic logic [7:0] ref_mix(input int code, input logic [7:0] s, input logic [7:0] d);
    logic [3:0] tt; // index {s,d}: bit3 s1d1, bit2 s1d0, bit1 s0d1, bit0 s0d0
    logic [7:0] r;
    case (code)
      0: tt = 4'b0000;  1: tt = 4'b1000;  2: tt = 4'b0100;  3: tt = 4'b1100;
      4: tt = 4'b0010;  5: tt = 4'b1010;  6: tt = 4'b0110;  7: tt = 4'b1110;
      8: tt = 4'b0001;  9: tt = 4'b1001;  10: tt = 4'b0101; 11: tt = 4'b1101;
      12: tt = 4'b0011; 13: tt = 4'b1011; 14: tt = 4'b0111; default: tt = 4'b1111;
    endcase
    for (int i = 0; i < 8; i++) r[i] = tt[{s[i], d[i]}];
    return r;
  endfunction

  function automatic int ctrl_word();
    return p_mix | (p_xn << 4) | (p_yn << 5) | (p_dm << 6) | (p_fs << 8) | (p_op << 12);
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'((i * 37 + seed * 11 + 5));
  endtask

  task automatic predict();
    for (int i = 0; i < MEMSZ; i++) ref_mem[i] = mem[i];
    exp_wr = 0;
    for (int y = 0; y < p_h; y++) begin
      for (int x = 0; x < p_w; x++) begin
        int sa, da;
        logic [7:0] s, d, r;
        if ((p_dm == 1 && x == 0) || (p_dm == 2 && x == p_w - 1)) continue;
        sa = p_src + (p_yn != 0 ? -y * p_sp : y * p_sp) + (p_xn != 0 ? -x : x);
        da = p_dst + (p_yn != 0 ? -y * p_dp : y * p_dp) + (p_xn != 0 ? -x : x);
        s = (p_fs != 0) ? mem[sa] : 8'(p_fg);
        d = mem[da];
        r = ref_mix(p_mix, s, d);
        if (p_op == 9) r = ~r;
        ref_mem[da] = r;
        exp_wr++;
      end
    end
    exp_rd = exp_wr * ((p_fs != 0) ? 2 : 1);
  endtask

  task automatic cfg_write(input int idx, input int data);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_idx = 4'(idx);
    cfg_wdata = 32'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_regs();
    cfg_write(0, p_src);
    cfg_write(1, p_dst);
    cfg_write(2, p_sp);
    cfg_write(3, p_dp);
    cfg_write(4, p_w - 1);
    cfg_write(5, p_h - 1);
    cfg_write(6, p_fg);
    cfg_write(7, ctrl_word());
  endtask

  task automatic launch_check(input string tag, input bit meddle);
    int n, mism, drop_cyc;
    predict();
    wr_cnt = 0; rd_cnt = 0; order_err = 0; oor = 0; last_wr_cyc = -1;
    cfg_write(8, 0);
    check(status == 8'h80, "R2", "status bit 7 after launch", status, 128);
    if (meddle) begin
      cfg_write(1, p_dst + 40);
      cfg_write(7, ctrl_word() ^ 32'h0000_200F);
      cfg_write(4, p_w + 2);
    end
    n = 0;
    while (status[7] && n < 5000) begin
      @(negedge clk);
      n++;
    end
    drop_cyc = cyc;
    check(n < 5000, "R11", "operation completes", n, 0);
    if (!(p_dm == 2) && !(p_dm == 1 && p_w == 1))
      check(drop_cyc == last_wr_cyc + 1, "R11", "busy drop cycle", drop_cyc, last_wr_cyc + 1);
    mism = 0;
    for (int i = 0; i < MEMSZ; i++) if (mem[i] !== ref_mem[i]) mism++;
    check(mism == 0 && oor == 0, tag, "frame buffer mismatches", mism + oor, 0);
    check(wr_cnt == exp_wr, "R9", "write count", wr_cnt, exp_wr);
    check(rd_cnt == exp_rd && order_err == 0, "R3", "read count / order errors",
          rd_cnt * 1000 + order_err, exp_rd * 1000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int seed;
    seed = 1;
    repeat (3) @(negedge clk);
    check(status == 8'h00 && !mem_valid, "R1", "status in reset", status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(status == 8'h00 && !mem_valid, "R1", "status after reset", status, 0);

    p_src = 200; p_dst = 700; p_sp = 16; p_dp = 20; p_fg = 8'h5A;

    // sweep mixes, both operations, both foreground sources (R6, R7, R8)
    for (int op = 8; op <= 9; op++) begin
      for (int fs = 0; fs < 2; fs++) begin
        for (int mx = 0; mx < 16; mx++) begin
          p_op = op; p_fs = fs; p_mix = mx; p_w = 3; p_h = 2;
          p_xn = 0; p_yn = 0; p_dm = 0;
          fill(seed++);
          load_regs();
          if (op == 9)      launch_check("R7", 1'b0);
          else if (fs == 0) launch_check("R8", 1'b0);
          else              launch_check("R6", 1'b0);
        end
      end
    end

    // sweep directions, draw modes and small sizes (R4, R5, R9)
    for (int dir = 0; dir < 4; dir++) begin
      for (int dm = 0; dm < 3; dm++) begin
        for (int w = 1; w <= 3; w++) begin
          for (int h = 1; h <= 3; h++) begin
            p_op = 8; p_fs = 1; p_mix = 6; p_w = w; p_h = h;
            p_xn = dir & 1; p_yn = (dir >> 1) & 1; p_dm = dm;
            fill(seed++);
            load_regs();
            if (dm != 0)                  launch_check("R9", 1'b0);
            else if (p_xn != 0 || p_yn != 0) launch_check("R5", 1'b0);
            else                          launch_check("R4", 1'b0);
          end
        end
      end
    end

    // wider rectangle with draw mode 3 (all pixels) (R4, R9)
    p_op = 8; p_fs = 1; p_mix = 3; p_w = 12; p_h = 5; p_xn = 0; p_yn = 0; p_dm = 3;
    p_sp = 24; p_dp = 30;
    fill(seed++);
    load_regs();
    launch_check("R4", 1'b0);

    // writes during busy are ignored, now and for the next launch (R10)
    p_sp = 16; p_dp = 20; p_op = 9; p_fs = 1; p_mix = 7; p_w = 3; p_h = 3; p_dm = 0;
    fill(seed++);
    load_regs();
    launch_check("R10", 1'b1);
    fill(seed++);
    launch_check("R10", 1'b0);

    // unknown operation code stays idle (R2)
    p_op = 5;
    fill(seed++);
    load_regs();
    wr_cnt = 0; rd_cnt = 0;
    cfg_write(8, 0);
    check(status == 8'h00, "R2", "status after rejected launch", status, 0);
    repeat (6) @(negedge clk);
    check(wr_cnt + rd_cnt == 0 && status == 8'h00, "R2", "traffic after rejected launch",
          wr_cnt + rd_cnt, 0);

    report();
  end

endmodule